// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This block is the combinational bit-field stage of a 64-bit integer datapath. Each evaluation takes a source operand, a destination operand (the old register value that inserts merge into), a 5-bit position, a 5-bit length-or-top field and a 3-bit operation code. It returns one 64-bit result in the same cycle. Extracts pull a contiguous field out of the source and right-justify it. Inserts overwrite a contiguous field of the destination with the low bits of the source and keep every other destination bit.

A 5-bit position can only name bits 0 to 31. Variant operations therefore add 32 to the top bound alone, or to both bounds, so that a field can lie in, or cross into, the upper half of the word. The two word-sized operations finish by sign-extending bit 31 of their result across bits 63 to 32. An insert whose bounds are inverted returns the destination with no change.

All bound arithmetic uses 7 bits. Sums above 63 are therefore detected and do not wrap, and field bits that would lie above bit 63 are dropped.

Top module: `bitfield_unit`

## Requirements
- R1: Opcode 0 (full extract) returns source bits pos through pos+len, shifted down to bit 0, with every result bit above bit len at zero.
- R2: Opcode 1 (mid extract) returns source bits pos through pos+len+32, shifted down to bit 0. Positions above 63 read as zero.
- R3: Opcode 2 (upper extract) returns source bits pos+32 through pos+len+32, shifted down to bit 0. Positions above 63 read as zero.
- R4: Opcode 3 (word extract) takes the field of R1 and then copies its bit 31 into bits 63 to 32.
- R5: Opcode 4 (full insert) with pos <= len sets result bits len down to pos to source bits (len-pos) down to 0. All other bits are taken from the destination.
- R6: Opcodes 4, 6 and 7 with pos > len return the destination unchanged in all 64 bits, with no sign extension.
- R7: Opcode 5 (mid insert) sets result bits len+32 down to pos from the source shifted left by pos. All other bits are taken from the destination.
- R8: Opcode 6 (upper insert) with pos <= len sets result bits len+32 down to pos+32 from the source shifted left by pos+32. All other bits are taken from the destination, including all of bits 31 to 0.
- R9: Opcode 7 (word insert) with pos <= len performs the merge of R5 and then copies bit 31 of the merged value into bits 63 to 32.
- R10: The block holds no state. The result follows the inputs in the same cycle, and all-zero inputs give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Source operand: the field origin for extracts and the field data for inserts |
| dst_i | input | 64 | Destination operand: the old value that inserts merge into |
| pos_i | input | 5 | Low bound of the field (before any offset) |
| len_i | input | 5 | Field size minus one for extracts, top bit for inserts (before any offset) |
| op_i | input | 3 | Operation code, 0 to 7, as listed in the requirements |
| result_o | output | 64 | Result of the selected operation |

## Verification
The bound checker is evaluated whenever the inputs change. It checks that a full extract leaves every bit above its length at zero. It checks that an inverted insert returns the destination unchanged, that the word operations sign-extend, and that the unselected bits of an insert keep the destination's value. When the requested field reaches past bit 63, it also checks that the mid and upper extracts equal a plain right shift of the source. Only the bench's sweep shows the exact field contents: it compares every operation, at every position and every length, against a bit-by-bit reference model, over several operand patterns.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

   typedef enum logic [2:0] {
      BF_EXT      = 3'd0,
      BF_EXT_MID  = 3'd1,
      BF_EXT_UP   = 3'd2,
      BF_EXT_W    = 3'd3,
      BF_INS      = 3'd4,
      BF_INS_MID  = 3'd5,
      BF_INS_UP   = 3'd6,
      BF_INS_W    = 3'd7
   } bf_op_e;

   typedef struct packed {
      logic is_ins;   // merge into destination instead of extracting
      logic is_word;  // sign-extend from the half-word boundary
      logic keep;     // inverted insert range: pass destination through
   } bf_ctrl_t;

endpackage

// File: rtl/bfu_bounds.sv
module bfu_bounds
   import bfu_pkg::*;
#(
   parameter int FIELD_W = 5,
   parameter int BND_W   = 7,
   parameter int HALF    = 32
) (
   input  logic [2:0]       op_i,
   input  logic [FIELD_W-1:0] pos_i,
   input  logic [FIELD_W-1:0] len_i,
   output logic [BND_W-1:0] lo_o,
   output logic [BND_W-1:0] hi_o,
   output bf_ctrl_t         ctrl_o
);

   localparam logic [BND_W-1:0] OFFS = BND_W'(HALF);

   logic [BND_W-1:0] pos_w;
   logic [BND_W-1:0] len_w;
   logic [BND_W-1:0] span;
   bf_op_e           op;

   assign pos_w = BND_W'(pos_i);
   assign len_w = BND_W'(len_i);
   assign span  = pos_w + len_w;
   assign op    = bf_op_e'(op_i);

   always_comb begin
      lo_o = pos_w;
      hi_o = span;
      unique case (op)
         BF_EXT:     begin lo_o = pos_w;        hi_o = span;         end
         BF_EXT_MID: begin lo_o = pos_w;        hi_o = span + OFFS;  end
         BF_EXT_UP:  begin lo_o = pos_w + OFFS; hi_o = span + OFFS;  end
         BF_EXT_W:   begin lo_o = pos_w;        hi_o = span;         end
         BF_INS:     begin lo_o = pos_w;        hi_o = len_w;        end
         BF_INS_MID: begin lo_o = pos_w;        hi_o = len_w + OFFS; end
         BF_INS_UP:  begin lo_o = pos_w + OFFS; hi_o = len_w + OFFS; end
         BF_INS_W:   begin lo_o = pos_w;        hi_o = len_w;        end
         default:    begin lo_o = pos_w;        hi_o = span;         end
      endcase
   end

   always_comb begin
      ctrl_o.is_ins  = op_i[2];
      ctrl_o.is_word = (op == BF_EXT_W) || (op == BF_INS_W);
      ctrl_o.keep    = op_i[2] && (lo_o > hi_o);
   end

endmodule

// File: rtl/bfu_mask.sv
module bfu_mask #(
   parameter int DATA_W    = 64,
   parameter int BND_W     = 7,
   parameter int MASK_IMPL = 0
) (
   input  logic [BND_W-1:0]  lo_i,
   input  logic [BND_W-1:0]  hi_i,
   output logic [DATA_W-1:0] mask_o
);

   generate
      if (MASK_IMPL == 0) begin : g_cmp
         // one pair of comparators per bit: shallow, wide
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign mask_o[i] = (BND_W'(i) >= lo_i) && (BND_W'(i) <= hi_i);
         end
      end else begin : g_shift
         // two thermometer codes from shifters: narrow, deeper
         localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
         localparam logic [BND_W-1:0]  TOP = BND_W'(DATA_W - 1);
         logic [DATA_W-1:0] upto_hi;
         logic [DATA_W-1:0] below_lo;
         always_comb begin
            if (hi_i >= TOP) upto_hi = '1;
            else             upto_hi = (ONE << (hi_i + BND_W'(1))) - ONE;
            if (lo_i > TOP)  below_lo = '1;
            else             below_lo = (ONE << lo_i) - ONE;
         end
         assign mask_o = upto_hi & ~below_lo;
      end
   endgenerate

endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
   import bfu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int BND_W  = 7
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [BND_W-1:0]  lo_i,
   input  logic [DATA_W-1:0] mask_i,
   input  bf_ctrl_t          ctrl_i,
   output logic [DATA_W-1:0] result_o
);

   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] extracted;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] raw;

   assign extracted = (src_i & mask_i) >> lo_i;
   assign merged    = (dst_i & ~mask_i) | ((src_i << lo_i) & mask_i);

   always_comb begin
      if (ctrl_i.keep)        raw = dst_i;
      else if (ctrl_i.is_ins) raw = merged;
      else                    raw = extracted;

      if (ctrl_i.is_word && !ctrl_i.keep)
         result_o = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
      else
         result_o = raw;
   end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
   import bfu_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int FIELD_W   = 5,
   parameter int MASK_IMPL = 0
) (
   input  logic [DATA_W-1:0]  src_i,
   input  logic [DATA_W-1:0]  dst_i,
   input  logic [FIELD_W-1:0] pos_i,
   input  logic [FIELD_W-1:0] len_i,
   input  logic [2:0]         op_i,
   output logic [DATA_W-1:0]  result_o
);

   localparam int HALF  = DATA_W / 2;
   localparam int BND_W = $clog2(DATA_W) + 1;
   localparam int FMAX  = (1 << FIELD_W) - 1;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_width
         $error("bitfield_unit: DATA_W must be even");
      end
      if (HALF < FMAX + 1) begin : g_bad_field
         $error("bitfield_unit: FIELD_W too wide for half word");
      end
      if (2 * FMAX + HALF >= (1 << BND_W)) begin : g_bad_bound
         $error("bitfield_unit: bound sum overflows bound width");
      end
      if (MASK_IMPL != 0 && MASK_IMPL != 1) begin : g_bad_impl
         $error("bitfield_unit: MASK_IMPL must be 0 or 1");
      end
   endgenerate

   logic [BND_W-1:0]  lo;
   logic [BND_W-1:0]  hi;
   logic [DATA_W-1:0] mask;
   bf_ctrl_t          ctrl;

   bfu_bounds #(
      .FIELD_W (FIELD_W),
      .BND_W   (BND_W),
      .HALF    (HALF)
   ) u_bounds (
      .op_i   (op_i),
      .pos_i  (pos_i),
      .len_i  (len_i),
      .lo_o   (lo),
      .hi_o   (hi),
      .ctrl_o (ctrl)
   );

   bfu_mask #(
      .DATA_W    (DATA_W),
      .BND_W     (BND_W),
      .MASK_IMPL (MASK_IMPL)
   ) u_mask (
      .lo_i   (lo),
      .hi_i   (hi),
      .mask_o (mask)
   );

   bfu_datapath #(
      .DATA_W (DATA_W),
      .BND_W  (BND_W)
   ) u_path (
      .src_i    (src_i),
      .dst_i    (dst_i),
      .lo_i     (lo),
      .mask_i   (mask),
      .ctrl_i   (ctrl),
      .result_o (result_o)
   );

endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
   parameter int DATA_W  = 64,
   parameter int FIELD_W = 5
) (
   input logic [DATA_W-1:0]  src_i,
   input logic [DATA_W-1:0]  dst_i,
   input logic [FIELD_W-1:0] pos_i,
   input logic [FIELD_W-1:0] len_i,
   input logic [2:0]         op_i,
   input logic [DATA_W-1:0]  result_o
);

   localparam int HALF  = DATA_W / 2;
   localparam int BND_W = $clog2(DATA_W) + 1;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [BND_W-1:0]  p;
   logic [BND_W-1:0]  l;
   logic [DATA_W-1:0] below_pos;
   logic [DATA_W-1:0] above_len;
   logic [DATA_W-1:0] diff;

   assign p         = BND_W'(pos_i);
   assign l         = BND_W'(len_i);
   assign below_pos = (ONE << p) - ONE;
   assign above_len = ~((ONE << (l + BND_W'(1))) - ONE);
   assign diff      = result_o ^ dst_i;

   always_comb begin
      if (op_i == 3'd0)
         p_ext_upper_zero_r1: assert ((result_o >> (l + BND_W'(1))) == '0)
            else $error("R1: full extract has bits set above length");
      if (op_i == 3'd1 && (p + l + BND_W'(HALF)) >= BND_W'(DATA_W - 1))
         p_ext_mid_to_top_r2: assert (result_o == (src_i >> p))
            else $error("R2: mid extract to top differs from shift");
      if (op_i == 3'd2 && (p + l) >= BND_W'(HALF - 1))
         p_ext_up_to_top_r3: assert (result_o == (src_i >> (p + BND_W'(HALF))))
            else $error("R3: upper extract to top differs from shift");
      if (op_i == 3'd3)
         p_ext_word_sext_r4: assert (result_o[DATA_W-1:HALF] == {HALF{result_o[HALF-1]}})
            else $error("R4: word extract not sign-extended");
      if (op_i == 3'd4 && p <= l)
         p_ins_outside_kept_r5: assert ((diff & (below_pos | above_len)) == '0)
            else $error("R5: insert changed bits outside field");
      if ((op_i == 3'd4 || op_i == 3'd6 || op_i == 3'd7) && p > l)
         p_ins_inverted_keep_r6: assert (result_o == dst_i)
            else $error("R6: inverted insert altered destination");
      if (op_i == 3'd5)
         p_ins_mid_low_kept_r7: assert ((diff & below_pos) == '0)
            else $error("R7: mid insert changed bits below position");
      if (op_i == 3'd6 && p <= l)
         p_ins_up_low_half_r8: assert (result_o[HALF-1:0] == dst_i[HALF-1:0])
            else $error("R8: upper insert changed low half");
      if (op_i == 3'd7 && p <= l)
         p_ins_word_sext_r9: assert (result_o[DATA_W-1:HALF] == {HALF{result_o[HALF-1]}})
            else $error("R9: word insert not sign-extended");
   end

endmodule

bind bitfield_unit bitfield_unit_chk #(
   .DATA_W  (DATA_W),
   .FIELD_W (FIELD_W)
) u_chk (
   .src_i    (src_i),
   .dst_i    (dst_i),
   .pos_i    (pos_i),
   .len_i    (len_i),
   .op_i     (op_i),
   .result_o (result_o)
);

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic [63:0] src;
   logic [63:0] dst;
   logic [4:0]  pos;
   logic [4:0]  len;
   logic [2:0]  op;
   logic [63:0] result;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bitfield_unit u_dut (
      .src_i    (src),
      .dst_i    (dst),
      .pos_i    (pos),
      .len_i    (len),
      .op_i     (op),
      .result_o (result)
   );

   // Bit-by-bit reference built from the requirements.
   function automatic logic [63:0] model(input int o, input logic [63:0] s,
                                         input logic [63:0] d, input int ps,
                                         input int ln);
      logic [63:0] r;
      int lo, hi;
      bit ins, word;
      ins  = (o >= 4);
      word = (o == 3) || (o == 7);
      case (o)
         0, 3:    begin lo = ps;      hi = ps + ln;      end
         1:       begin lo = ps;      hi = ps + ln + 32; end
         2:       begin lo = ps + 32; hi = ps + ln + 32; end
         5:       begin lo = ps;      hi = ln + 32;      end
         6:       begin lo = ps + 32; hi = ln + 32;      end
         default: begin lo = ps;      hi = ln;           end
      endcase
      if (ins) begin
         if (lo > hi) return d;
         r = d;
         for (int i = lo; i <= hi && i < 64; i++) r[i] = s[i - lo];
      end else begin
         r = '0;
         for (int k = 0; lo + k <= hi && lo + k < 64; k++) r[k] = s[lo + k];
      end
      if (word) r = {{32{r[31]}}, r[31:0]};
      return r;
   endfunction

   function automatic string tag_of(input int o, input int ps, input int ln);
      if ((o == 4 || o == 6 || o == 7) && ps > ln) return "R6";
      case (o)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R7";
         6: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic apply_check(input int o, input logic [63:0] s,
                              input logic [63:0] d, input int ps,
                              input int ln, input string tag);
      logic [63:0] exp;
      @(negedge clk);
      op  = 3'(o);
      src = s;
      dst = d;
      pos = 5'(ps);
      len = 5'(ln);
      #1;
      exp = model(o, s, d, ps, ln);
      checks++;
      if (result !== exp) begin
         failures++;
         $display("FAIL %s op=%0d pos=%0d len=%0d actual=%h expected=%h",
                  tag, o, ps, ln, result, exp);
      end
   endtask

   initial begin
      op = '0; src = '0; dst = '0; pos = '0; len = '0;
      #1;
      // R10: stateless, all-zero inputs give zero at once
      checks++;
      if (result !== 64'd0) begin
         failures++;
         $display("FAIL R10 actual=%h expected=%h", result, 64'd0);
      end

      // R10: result follows a change of inputs within the same cycle
      apply_check(0, 64'hFFFF_FFFF_FFFF_FFFF, '0, 4, 3, "R10");

      // Corner cases called out by the requirements
      apply_check(0, 64'h8000_0000_0000_0001, '0, 31, 31, "R1");
      apply_check(1, 64'hDEAD_BEEF_0123_4567, '0, 31, 31, "R2");
      apply_check(2, 64'h8123_4567_89AB_CDEF, '0, 31, 31, "R3");
      apply_check(3, 64'h0000_0000_8000_0000, '0, 0, 31, "R4");
      apply_check(3, 64'h0000_0000_7FFF_FFFF, '0, 0, 31, "R4");
      apply_check(4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5, 9, "R5");
      apply_check(4, 64'h1, 64'h5555_5555_5555_5555, 9, 5, "R6");
      apply_check(6, 64'h1, 64'h5555_5555_5555_5555, 20, 3, "R6");
      apply_check(7, 64'h1, 64'h8000_0000_0000_0000, 20, 3, "R6");
      apply_check(5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 31, 0, "R7");
      apply_check(6, 64'hFFFF_FFFF, 64'h0, 0, 31, "R8");
      apply_check(7, 64'h8000_0000, 64'h0, 31, 31, "R9");

      // Sweep of every operation, position and length over operand patterns
      for (int pat = 0; pat < 4; pat++) begin
         for (int o = 0; o < 8; o++) begin
            for (int ps = 0; ps < 32; ps++) begin
               for (int ln = 0; ln < 32; ln++) begin
                  logic [63:0] s, d;
                  case (pat)
                     0: begin s = 64'hF0E1_D2C3_B4A5_9687; d = 64'h0123_4567_89AB_CDEF; end
                     1: begin s = 64'h0F1E_2D3C_4B5A_6978; d = 64'hFEDC_BA98_7654_3210; end
                     2: begin s = 64'hFFFF_FFFF_FFFF_FFFF; d = 64'h0; end
                     default: begin s = {ps[31:0], ~ln[31:0]}; d = {~ps[31:0], ln[31:0]}; end
                  endcase
                  apply_check(o, s, d, ps, ln, tag_of(o, ps, ln));
               end
            end
         end
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule